// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block services a translation miss for a 32-bit virtual address by reading descriptors from memory and producing either a physical address with its attribute bits or a translation fault. It accepts one miss at a time. It picks one of two table base registers from the upper bits of the address. It then reads a first-level descriptor and, when that descriptor points to a second-level table, reads a second descriptor. Four mapping granules are supported: 1 MB sections, 16 MB supersections with a 40-bit result, 4 KB small pages and 64 KB large pages.

Descriptor reads go out over a minimal memory port. The walker raises a one-cycle request carrying a word address, then waits for a response strobe with the descriptor word, however many cycles that takes. Each walk ends with a single-cycle completion pulse that carries the result fields. The walker is idle again on the following cycle.

A control field `split_n` (0..7) sets how much of the address space belongs to the low base register. An address whose top `split_n` bits are all zero walks the low table. Every other address walks the high table. When `split_n` is zero, every address walks the low table.

Top module: `xlat_walker`

## Requirements
- R1: The low base `tbl_base_lo` is used when `split_n` is 0 or when the top `split_n` bits of the VA are all zero; otherwise the high base `tbl_base_hi` is used.
- R2: The first-level read address is the chosen base with its low 14 bits cleared (high table) or its low 14−n bits cleared (low table), ORed with 4 × index. The index is VA[31:20]; for the low table it is reduced to its low 12−n bits.
- R3: A first-level descriptor with bits[1:0]=2 is a section. The walker gives done_kind=0, done_pa = {8'h00, desc[31:20], VA[19:0]} and done_attr = desc[11:2], after exactly one read.
- R4: A first-level descriptor with bits[1:0]=3 is a supersection. The walker gives done_kind=1, done_pa = {desc[23:16], desc[31:24], VA[23:0]} and done_attr = desc[11:2], after exactly one read.
- R5: A first-level descriptor with bits[1:0]=1 points to a second-level table. The second read goes to {desc[31:10], VA[19:12], 2'b00}.
- R6: A second-level descriptor with bits[1:0]=2 is a small page. The walker gives done_kind=2, done_pa = {8'h00, desc[31:12], VA[11:0]} and done_attr = desc[11:2], after two reads.
- R7: A second-level descriptor with bits[1:0]=1 is a large page. The walker gives done_kind=3, done_pa = {8'h00, desc[31:16], VA[15:0]} and done_attr = desc[11:2], after two reads.
- R8: A first-level descriptor with bits[1:0]=0 ends the walk after one read with done_fault=1, done_fault_l2=0, and zero pa, attr and kind.
- R9: A second-level descriptor with bits[1:0]=0 or 3 ends the walk after two reads with done_fault=1, done_fault_l2=1, and zero pa, attr and kind.
- R10: req_ready is high only while idle. A request presented while a walk is in flight is ignored. done_valid is a one-cycle pulse, and req_ready is high on the cycle after it.
- R11: After reset, req_ready=1, mem_req_valid=0 and done_valid=0.
- R12: Each descriptor read is a one-cycle mem_req_valid pulse, and at most one read is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Miss request strobe |
| req_ready | output | 1 | Walker idle, request accepted this cycle |
| req_va | input | 32 | Virtual address to translate |
| tbl_base_lo | input | 32 | Base of the low-region first-level table |
| tbl_base_hi | input | 32 | Base of the high-region first-level table |
| split_n | input | 3 | Number of top VA bits that pick the table |
| mem_req_valid | output | 1 | Descriptor read request pulse |
| mem_req_addr | output | 32 | Descriptor word address |
| mem_rsp_valid | input | 1 | Descriptor read data valid |
| mem_rsp_data | input | 32 | Descriptor word |
| done_valid | output | 1 | Walk completion pulse |
| done_fault | output | 1 | Walk ended in a translation fault |
| done_fault_l2 | output | 1 | Fault came from the second level |
| done_kind | output | 2 | 0 section, 1 supersection, 2 small page, 3 large page |
| done_pa | output | 40 | Physical address |
| done_attr | output | 10 | Attribute bits of the leaf descriptor |

## Verification
The walks cover every descriptor type at both levels, and compare each result field with a model computed from the written descriptors. One section address has its top bit set while the split is zero, which shows that the split field alone forces the low base. Addresses just inside and just outside the low region at splits of 2 and 7 exercise base choice and index masking, using an unaligned low base. The bench checks the read count and the first read address of each walk against the model, which separates a one-read leaf from a two-read page. Varied response latencies and a request held high during a walk show that a busy walker accepts nothing.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int VA_W     = 32;
  localparam int PA_W     = 40;
  localparam int ATTR_W   = 10;
  localparam int SPLIT_W  = 3;
  localparam int EXT_W    = PA_W - VA_W;
  localparam int SEC_OFF  = 20;
  localparam int SUP_OFF  = 24;
  localparam int SML_OFF  = 12;
  localparam int LRG_OFF  = 16;
  localparam int L1_IDX_W = VA_W - SEC_OFF;
  localparam int L1_SPAN  = L1_IDX_W + 2;
  localparam int L2_IDX_W = SEC_OFF - SML_OFF;
  localparam int L2_LSB   = L2_IDX_W + 2;

  typedef enum logic [1:0] {
    PK_SECTION = 2'd0,
    PK_SUPER   = 2'd1,
    PK_SMALL   = 2'd2,
    PK_LARGE   = 2'd3
  } page_kind_e;

  typedef enum logic [2:0] {
    S_IDLE, S_L1_ISSUE, S_L1_WAIT, S_L2_ISSUE, S_L2_WAIT, S_DONE
  } walk_state_e;

  typedef struct packed {
    logic              fault;
    logic              fault_l2;
    page_kind_e        kind;
    logic [PA_W-1:0]   pa;
    logic [ATTR_W-1:0] attr;
  } walk_res_t;

  // descriptor type codes, bits [1:0]
  localparam logic [1:0] L1_INVALID = 2'd0;
  localparam logic [1:0] L1_TABLE   = 2'd1;
  localparam logic [1:0] L1_SECTION = 2'd2;
  localparam logic [1:0] L1_SUPER   = 2'd3;
  localparam logic [1:0] L2_LARGE   = 2'd1;
  localparam logic [1:0] L2_SMALL   = 2'd2;

  function automatic logic hi_region(input logic [VA_W-1:0] va,
                                     input logic [SPLIT_W-1:0] n);
    logic [VA_W-1:0] top;
    if (n == '0) return 1'b0;
    top = va >> (VA_W - int'(n));
    return top != '0;
  endfunction

  function automatic logic [VA_W-1:0] l1_desc_addr(input logic [VA_W-1:0] base,
                                                   input logic [VA_W-1:0] va,
                                                   input logic [SPLIT_W-1:0] n,
                                                   input logic hi);
    logic [VA_W-1:0] keep_mask;
    logic [VA_W-1:0] idx_mask;
    logic [VA_W-1:0] idx;
    int shrink;
    shrink    = hi ? 0 : int'(n);
    keep_mask = {VA_W{1'b1}} << (L1_SPAN - shrink);
    idx_mask  = ~({VA_W{1'b1}} << (L1_IDX_W - shrink));
    idx       = (va >> SEC_OFF) & idx_mask;
    return (base & keep_mask) | (idx << 2);
  endfunction

  function automatic logic [VA_W-1:0] l2_desc_addr(input logic [VA_W-1:0] desc,
                                                   input logic [VA_W-1:0] va);
    return {desc[VA_W-1:L2_LSB], va[SEC_OFF-1:SML_OFF], 2'b00};
  endfunction

  function automatic walk_res_t fault_res(input logic second);
    walk_res_t r;
    r          = '0;
    r.fault    = 1'b1;
    r.fault_l2 = second;
    return r;
  endfunction

  function automatic walk_res_t leaf_res(input page_kind_e kind,
                                         input logic [VA_W-1:0] desc,
                                         input logic [VA_W-1:0] va);
    walk_res_t r;
    r      = '0;
    r.kind = kind;
    r.attr = desc[ATTR_W+1:2];
    case (kind)
      PK_SECTION: r.pa = PA_W'({desc[VA_W-1:SEC_OFF], va[SEC_OFF-1:0]});
      PK_SUPER:   r.pa = {desc[SUP_OFF-1 -: EXT_W], desc[VA_W-1:SUP_OFF], va[SUP_OFF-1:0]};
      PK_SMALL:   r.pa = PA_W'({desc[VA_W-1:SML_OFF], va[SML_OFF-1:0]});
      default:    r.pa = PA_W'({desc[VA_W-1:LRG_OFF], va[LRG_OFF-1:0]});
    endcase
    return r;
  endfunction
endpackage

// File: rtl/xlat_base_sel.sv
module xlat_base_sel
  import xlat_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [VA_W-1:0]    va,
  input  logic [VA_W-1:0]    base_lo,
  input  logic [VA_W-1:0]    base_hi,
  input  logic [SPLIT_W-1:0] split,
  output logic               use_hi,
  output logic [VA_W-1:0]    l1_addr
);
  always_comb begin
    use_hi  = hi_region(va, split);
    l1_addr = l1_desc_addr(use_hi ? base_hi : base_lo, va, split, use_hi);
  end

  AST_HI_NEEDS_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
    use_hi |-> (split != '0)); // R1
  AST_L1_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    l1_addr[1:0] == 2'b00); // R2
endmodule

// File: rtl/xlat_l1_decode.sv
module xlat_l1_decode
  import xlat_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [VA_W-1:0] desc,
  input  logic [VA_W-1:0] va,
  output logic            is_table,
  output logic [VA_W-1:0] l2_addr,
  output walk_res_t       res
);
  always_comb begin
    is_table = 1'b0;
    l2_addr  = l2_desc_addr(desc, va);
    case (desc[1:0])
      L1_TABLE: begin
        is_table = 1'b1;
        res      = '0;
      end
      L1_SECTION: res = leaf_res(PK_SECTION, desc, va);
      L1_SUPER:   res = leaf_res(PK_SUPER, desc, va);
      default:    res = fault_res(1'b0);
    endcase
  end

  AST_L1_TABLE_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    is_table |-> !res.fault); // R5
  AST_L1_SECTION_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_table && !res.fault && res.kind == PK_SECTION) |->
      res.pa[SEC_OFF-1:0] == va[SEC_OFF-1:0]); // R3
  AST_L1_FAULT_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    res.fault |-> !res.fault_l2); // R8
endmodule

// File: rtl/xlat_l2_decode.sv
module xlat_l2_decode
  import xlat_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [VA_W-1:0] desc,
  input  logic [VA_W-1:0] va,
  output walk_res_t       res
);
  always_comb begin
    case (desc[1:0])
      L2_SMALL: res = leaf_res(PK_SMALL, desc, va);
      L2_LARGE: res = leaf_res(PK_LARGE, desc, va);
      default:  res = fault_res(1'b1);
    endcase
  end

  AST_L2_FAULT_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    res.fault |-> res.fault_l2); // R9
  AST_L2_SMALL_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    (!res.fault && res.kind == PK_SMALL) |->
      res.pa[SML_OFF-1:0] == va[SML_OFF-1:0]); // R6
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
  import xlat_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [VA_W-1:0]    req_va,
  input  logic [VA_W-1:0]    tbl_base_lo,
  input  logic [VA_W-1:0]    tbl_base_hi,
  input  logic [SPLIT_W-1:0] split_n,
  output logic               mem_req_valid,
  output logic [VA_W-1:0]    mem_req_addr,
  input  logic               mem_rsp_valid,
  input  logic [VA_W-1:0]    mem_rsp_data,
  output logic               done_valid,
  output logic               done_fault,
  output logic               done_fault_l2,
  output logic [1:0]         done_kind,
  output logic [PA_W-1:0]    done_pa,
  output logic [ATTR_W-1:0]  done_attr
);
  walk_state_e     state_q;
  logic [VA_W-1:0] va_q;
  logic [VA_W-1:0] addr_q;
  walk_res_t       res_q;

  logic            use_hi;
  logic [VA_W-1:0] l1_addr;
  logic            is_table;
  logic [VA_W-1:0] l2_addr;
  walk_res_t       l1_res;
  walk_res_t       l2_res;

  // named events for the checks
  logic ev_accept, ev_l1_rsp, ev_l2_rsp, ev_to_l2;
  assign ev_accept = req_valid && (state_q == S_IDLE);
  assign ev_l1_rsp = mem_rsp_valid && (state_q == S_L1_WAIT);
  assign ev_l2_rsp = mem_rsp_valid && (state_q == S_L2_WAIT);
  assign ev_to_l2  = ev_l1_rsp && is_table;

  xlat_base_sel u_base_sel (
    .clk     (clk),
    .rst_n   (rst_n),
    .va      (req_va),
    .base_lo (tbl_base_lo),
    .base_hi (tbl_base_hi),
    .split   (split_n),
    .use_hi  (use_hi),
    .l1_addr (l1_addr)
  );

  xlat_l1_decode u_l1_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .desc     (mem_rsp_data),
    .va       (va_q),
    .is_table (is_table),
    .l2_addr  (l2_addr),
    .res      (l1_res)
  );

  xlat_l2_decode u_l2_dec (
    .clk   (clk),
    .rst_n (rst_n),
    .desc  (mem_rsp_data),
    .va    (va_q),
    .res   (l2_res)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      va_q    <= '0;
      addr_q  <= '0;
      res_q   <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (ev_accept) begin
          va_q    <= req_va;
          addr_q  <= l1_addr;
          state_q <= S_L1_ISSUE;
        end
        S_L1_ISSUE: state_q <= S_L1_WAIT;
        S_L1_WAIT: if (ev_l1_rsp) begin
          if (is_table) begin
            addr_q  <= l2_addr;
            state_q <= S_L2_ISSUE;
          end else begin
            res_q   <= l1_res;
            state_q <= S_DONE;
          end
        end
        S_L2_ISSUE: state_q <= S_L2_WAIT;
        S_L2_WAIT: if (ev_l2_rsp) begin
          res_q   <= l2_res;
          state_q <= S_DONE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign req_ready     = (state_q == S_IDLE);
  assign mem_req_valid = (state_q == S_L1_ISSUE) || (state_q == S_L2_ISSUE);
  assign mem_req_addr  = addr_q;
  assign done_valid    = (state_q == S_DONE);
  assign done_fault    = res_q.fault;
  assign done_fault_l2 = res_q.fault_l2;
  assign done_kind     = res_q.kind;
  assign done_pa       = res_q.pa;
  assign done_attr     = res_q.attr;

  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> !mem_req_valid); // R12
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> (!done_valid && req_ready)); // R10
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> !req_ready); // R10
  AST_LEAF_ONE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_l1_rsp && !is_table) |=> done_valid); // R3
  AST_TABLE_SECOND_READ: assert property (@(posedge clk) disable iff (!rst_n)
    ev_to_l2 |=> mem_req_valid); // R5
  AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && done_fault) |-> (done_pa == '0 && done_attr == '0)); // R8
  AST_SUPER_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && !done_fault && done_kind == PK_SUPER) |->
      done_pa[SUP_OFF-1:0] == va_q[SUP_OFF-1:0]); // R4
  AST_LARGE_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && !done_fault && done_kind == PK_LARGE) |->
      done_pa[LRG_OFF-1:0] == va_q[LRG_OFF-1:0]); // R7
endmodule

// File: tb/xlat_walker_bench.sv
`timescale 1ns/1ps
module xlat_walker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_va = '0;
  logic [31:0] tbl_base_lo = '0;
  logic [31:0] tbl_base_hi = '0;
  logic [2:0]  split_n = '0;
  logic        mem_req_valid;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        done_valid, done_fault, done_fault_l2;
  logic [1:0]  done_kind;
  logic [39:0] done_pa;
  logic [9:0]  done_attr;

  always #2.5 clk = ~clk;

  xlat_walker u_xlat_walker (.*);

  typedef struct {
    string       tag;
    logic        fault;
    logic        fault_l2;
    logic [1:0]  kind;
    logic [39:0] pa;
    logic [9:0]  attr;
    int          reads;
    logic [31:0] l1a;
  } exp_t;

  exp_t        sb[$];
  logic [31:0] mem_img [logic [31:0]];
  int          checks = 0;
  int          errors = 0;
  int          lat = 1;
  int          rd_count = 0;
  logic [31:0] first_addr = '0;
  bit          finished = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // memory model: one-cycle request, response after lat cycles
  always @(negedge clk) begin
    int  cnt;
    bit  pend;
    logic [31:0] a;
    mem_rsp_valid = 1'b0;
    if (!rst_n) begin
      pend = 0;
    end else begin
      if (req_valid && req_ready) rd_count = 0;
      if (mem_req_valid) begin
        pend = 1; cnt = lat; a = mem_req_addr;
        rd_count++;
        if (rd_count == 1) first_addr = mem_req_addr;
      end else if (pend) begin
        cnt--;
        if (cnt <= 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = mem_img.exists(a) ? mem_img[a] : 32'h0;
          pend = 0;
        end
      end
    end
  end

  // monitor: compare each completion with the scoreboard head
  always @(negedge clk) begin
    exp_t e;
    if (rst_n && done_valid) begin
      if (sb.size() == 0) begin
        chk(0, "R10", "unexpected completion", 64'(done_pa), 64'h0);
      end else begin
        e = sb.pop_front();
        chk(done_fault === e.fault,       e.tag, "fault",    64'(done_fault), 64'(e.fault));
        chk(done_fault_l2 === e.fault_l2, e.tag, "fault_l2", 64'(done_fault_l2), 64'(e.fault_l2));
        chk(done_kind === e.kind,         e.tag, "kind",     64'(done_kind), 64'(e.kind));
        chk(done_pa === e.pa,             e.tag, "pa",       64'(done_pa), 64'(e.pa));
        chk(done_attr === e.attr,         e.tag, "attr",     64'(done_attr), 64'(e.attr));
        chk(rd_count == e.reads,          e.tag, "reads",    64'(rd_count), 64'(e.reads));
        chk(first_addr === e.l1a,         e.tag, "l1 addr",  64'(first_addr), 64'(e.l1a));
      end
    end
  end

  function automatic logic [31:0] model_l1(input logic [31:0] va);
    int n = int'(split_n);
    longint span;
    if (n != 0 && (va >> (32 - n)) != 0)
      return (tbl_base_hi / 32'd16384) * 32'd16384 + (va >> 20) * 4;
    span = longint'(1) << (14 - n);
    return 32'((longint'(tbl_base_lo) / span) * span +
               ((longint'(va) >> 20) % (longint'(1) << (12 - n))) * 4);
  endfunction

  task automatic walk(input string tag, input logic [31:0] va,
                      input logic [31:0] d1, input logic [31:0] d2,
                      input int l, input bit hold_busy);
    exp_t e;
    logic [31:0] a1, a2;
    mem_img.delete();
    lat = l;
    a1 = model_l1(va);
    mem_img[a1] = d1;
    e = '{tag: tag, fault: 0, fault_l2: 0, kind: 0, pa: 0, attr: 0, reads: 1, l1a: a1};
    case (d1 % 4)
      0: e.fault = 1;                                       // R8
      2: begin
        e.kind = 0; e.attr = 10'((d1 >> 2) % 1024);
        e.pa = (40'(d1 >> 20) << 20) + 40'(va % (32'd1 << 20));
      end
      3: begin
        e.kind = 1; e.attr = 10'((d1 >> 2) % 1024);
        e.pa = (40'((d1 >> 16) % 256) << 32) + (40'(d1 >> 24) << 24) + 40'(va % (32'd1 << 24));
      end
      default: begin
        a2 = (d1 / 1024) * 1024 + ((va >> 12) % 256) * 4;   // R5
        mem_img[a2] = d2;
        e.reads = 2;
        case (d2 % 4)
          2: begin
            e.kind = 2; e.attr = 10'((d2 >> 2) % 1024);
            e.pa = (40'(d2 >> 12) << 12) + 40'(va % 4096);
          end
          1: begin
            e.kind = 3; e.attr = 10'((d2 >> 2) % 1024);
            e.pa = (40'(d2 >> 16) << 16) + 40'(va % 65536);
          end
          default: begin e.fault = 1; e.fault_l2 = 1; end
        endcase
      end
    endcase
    sb.push_back(e);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_va = va; req_valid = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b0, "R10", "ready while busy", 64'(req_ready), 64'h0);
    if (hold_busy) begin
      req_va = ~va;
      @(negedge clk);
    end
    req_valid = 1'b0;
    while (sb.size() != 0) @(negedge clk);
  endtask

  task automatic set_cfg(input logic [31:0] lo, input logic [31:0] hi, input logic [2:0] n);
    tbl_base_lo = lo; tbl_base_hi = hi; split_n = n;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready === 1'b1,     "R11", "reset ready", 64'(req_ready), 64'h1);
    chk(mem_req_valid === 1'b0, "R11", "reset mem req", 64'(mem_req_valid), 64'h0);
    chk(done_valid === 1'b0,    "R11", "reset done", 64'(done_valid), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    set_cfg(32'h0004_0000, 32'h0008_0000, 3'd0);
    walk("R1 split0 section", 32'hFFF1_2345, 32'hABC0_0DAE, 0, 1, 0);
    walk("R3 section", 32'h1234_5678, 32'h5550_03F2, 0, 2, 0);

    set_cfg(32'h0004_0000, 32'h0008_0000, 3'd2);
    walk("R4 supersection", 32'h2345_6789, 32'h5A7C_0F5F, 0, 2, 0);
    walk("R1 high section", 32'hC123_4567, 32'h0010_0126, 0, 1, 0);
    walk("R6 small page", 32'h4567_89AB, 32'h0012_3401, 32'h9876_5A3A, 3, 0);
    walk("R7 large page", 32'h0ABC_DEF0, 32'h0033_0C01, 32'h1357_9BE5, 2, 0);
    walk("R8 l1 invalid", 32'h8000_0000, 32'hFFFF_FFFC, 0, 1, 0);
    walk("R9 l2 type0", 32'h1111_2222, 32'h0044_0001, 32'h1234_5670, 1, 0);
    walk("R9 l2 type3", 32'h3FFF_F000, 32'h0044_0401, 32'h1234_567F, 2, 0);

    set_cfg(32'h0000_1FF0, 32'h0020_0000, 3'd7);
    walk("R2 split7 low", 32'h01F0_0000, 32'h7770_0002, 0, 1, 0);
    walk("R1 split7 high", 32'h0200_0000, 32'h7780_0006, 0, 1, 0);

    walk("R10 busy ignore", 32'h0123_4567, 32'h0066_0001, 32'h2468_ACE2, 4, 1);
    walk("R12 fast small", 32'h0155_5555, 32'h0077_0001, 32'h0BAD_F00E, 1, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule